// File: doc/BRIEF.md
# Escaped Command Packet Receiver

This block sits behind a serial byte receiver and turns a raw stream of bytes into checked command packets. One byte arrives with each cycle in which `rx_valid` is high. The block first searches for a pair of start markers. It then strips the escape bytes that protect control-valued data and collects the fields in order: a command byte, a length byte, that many payload bytes, a checksum byte, and finally an end marker.

Payload bytes go straight into an internal buffer as they arrive. The command and length are published only when a packet closes cleanly. At that point a single-cycle `pkt_valid` pulse tells the command layer that a packet is ready. The command layer then reads the payload through a combinational read port.

Any fault drops the packet in silence and the block hunts for the next start. Faults are a bad checksum, a missing end marker, an oversized length, or a stray control code. Nothing is sent back to the host.

Top module: `pkt_deframer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `pkt_valid` is 0 and `pkt_cmd` and `pkt_len` are 0.
- R2: A packet begins only after two consecutive unescaped start bytes (`STX_CODE`, default 0Fh). A single start byte followed by any other byte returns the block to hunting. Extra unescaped start bytes while the command byte is awaited are ignored.
- R3: After the start pair, the fields arrive in this order: command, length, payload bytes, checksum, then an unescaped end byte (`ETX_CODE`, default 05h). On a good packet, `pkt_valid` is high in the cycle after the clock edge that takes the end byte. In that same cycle, `pkt_cmd` and `pkt_len` carry the packet's values and `rd_data` returns payload byte `rd_addr`.
- R4: An unescaped byte equal to `DLE_CODE` (default 04h) is discarded, and the following byte is taken literally as a data byte, whatever its value. Discarded escape bytes count toward neither the length nor the checksum.
- R5: The 8-bit sum of the command, length, payload and checksum bytes must be 0 modulo 256. Otherwise the packet is dropped with no `pkt_valid`.
- R6: If the byte after the checksum is not an unescaped end byte, the packet is dropped.
- R7: A length byte greater than `BUF_DEPTH` drops the packet. A length exactly equal to `BUF_DEPTH` is accepted.
- R8: An unescaped start byte in the length, payload, checksum or end position abandons the current packet and counts as the first byte of a new start pair.
- R9: `pkt_valid` lasts exactly one cycle. `pkt_cmd` and `pkt_len` change only together with a `pkt_valid` pulse, so dropped packets leave them unchanged.
- R10: A packet with length 0 (command, length, checksum, end) is accepted.
- R11: Cycles with `rx_valid` low between bytes have no effect on the packet being received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| rd_addr | input | 8 | Payload buffer read index |
| rd_data | output | 8 | Payload byte at `rd_addr` (0 beyond the buffer) |
| pkt_valid | output | 1 | One-cycle pulse for an accepted packet |
| pkt_cmd | output | 8 | Command of the last accepted packet |
| pkt_len | output | 8 | Payload length of the last accepted packet |

## Verification
Every result of an accepted packet is due exactly one cycle after the edge that takes its end byte; the escape stage adds no delay. The scoreboard records, for each good packet, the cycle number in which that end byte was driven plus one. The monitor samples on falling edges and compares `pkt_valid`, command and length against that due cycle. While the clock is still low it sweeps `rd_addr` over the payload to read the buffer, then checks on the next falling edge that the pulse has dropped. Dropped packets push nothing, so any pulse they caused surfaces as an unexpected or mismatched entry, and the bench rechecks that the held command did not move.

// File: rtl/pkt_deframer_pkg.sv
package pkt_deframer_pkg;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_SYNC,
        ST_CMD,
        ST_LEN,
        ST_DATA,
        ST_SUM,
        ST_TAIL
    } fr_state_e;

    // one byte after escape removal
    typedef struct packed {
        logic [7:0] val;
        logic       lit;   // preceded by an escape byte
        logic       vld;
    } sym_t;

endpackage

// File: rtl/pkt_unescape.sv
module pkt_unescape
    import pkt_deframer_pkg::*;
#(
    parameter logic [7:0] DLE_CODE = 8'h04
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_vld,
    input  logic [7:0] in_byte,
    output sym_t       sym
);

    logic esc_d, esc_q;

    always_comb begin
        esc_d = esc_q;
        sym   = '0;
        if (in_vld) begin
            if (!esc_q && in_byte == DLE_CODE) begin
                esc_d = 1'b1;
            end else begin
                sym.vld = 1'b1;
                sym.val = in_byte;
                sym.lit = esc_q;
                esc_d   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) esc_q <= 1'b0;
        else        esc_q <= esc_d;
    end

endmodule

// File: rtl/pkt_payload_ram.sv
module pkt_payload_ram #(
    parameter int DEPTH = 255,
    parameter int AW    = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [7:0]    wd,
    input  logic [AW-1:0] ra,
    output logic [7:0]    rd
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[wa] <= wd;
    end

    assign rd = mem[ra];

endmodule

// File: rtl/pkt_frame_fsm.sv
module pkt_frame_fsm
    import pkt_deframer_pkg::*;
#(
    parameter logic [7:0] STX_CODE = 8'h0F,
    parameter logic [7:0] ETX_CODE = 8'h05,
    parameter int         DEPTH    = 255,
    parameter int         AW       = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  sym_t          sym,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic          pkt_valid,
    output logic [7:0]    pkt_cmd,
    output logic [7:0]    pkt_len
);

    typedef struct packed {
        fr_state_e  st;
        logic [7:0] cmd;
        logic [7:0] len;
        logic [7:0] cnt;
        logic [7:0] sum;
        logic [7:0] cmd_out;
        logic [7:0] len_out;
        logic       valid;
    } ctx_t;

    localparam logic [8:0] LEN_MAX = 9'(DEPTH);

    ctx_t       r_d, r_q;
    logic       is_stx, is_etx, is_dat;
    logic [7:0] sum_nx;

    always_comb begin
        is_stx  = sym.vld && !sym.lit && sym.val == STX_CODE;
        is_etx  = sym.vld && !sym.lit && sym.val == ETX_CODE;
        is_dat  = sym.vld && !is_stx && !is_etx;
        sum_nx  = r_q.sum + sym.val;

        r_d       = r_q;
        r_d.valid = 1'b0;
        wr_en     = 1'b0;
        wr_addr   = r_q.cnt[AW-1:0];
        wr_data   = sym.val;

        unique case (r_q.st)
            ST_HUNT: begin
                if (is_stx) r_d.st = ST_SYNC;
            end
            ST_SYNC: begin
                if (is_stx)       r_d.st = ST_CMD;
                else if (sym.vld) r_d.st = ST_HUNT;
            end
            ST_CMD: begin
                // repeated start bytes keep waiting for the command
                if (is_etx) begin
                    r_d.st = ST_HUNT;
                end else if (is_dat) begin
                    r_d.cmd = sym.val;
                    r_d.sum = sym.val;
                    r_d.st  = ST_LEN;
                end
            end
            ST_LEN: begin
                if (is_stx) begin
                    r_d.st = ST_SYNC;
                end else if (is_etx) begin
                    r_d.st = ST_HUNT;
                end else if (is_dat) begin
                    if ({1'b0, sym.val} > LEN_MAX) begin
                        r_d.st = ST_HUNT;
                    end else begin
                        r_d.len = sym.val;
                        r_d.sum = sum_nx;
                        r_d.cnt = 8'd0;
                        r_d.st  = (sym.val == 8'd0) ? ST_SUM : ST_DATA;
                    end
                end
            end
            ST_DATA: begin
                if (is_stx) begin
                    r_d.st = ST_SYNC;
                end else if (is_etx) begin
                    r_d.st = ST_HUNT;
                end else if (is_dat) begin
                    wr_en   = 1'b1;
                    r_d.sum = sum_nx;
                    r_d.cnt = r_q.cnt + 8'd1;
                    if (r_q.cnt + 8'd1 == r_q.len) r_d.st = ST_SUM;
                end
            end
            ST_SUM: begin
                if (is_stx) begin
                    r_d.st = ST_SYNC;
                end else if (is_etx) begin
                    r_d.st = ST_HUNT;
                end else if (is_dat) begin
                    r_d.sum = sum_nx;
                    r_d.st  = (sum_nx == 8'd0) ? ST_TAIL : ST_HUNT;
                end
            end
            ST_TAIL: begin
                if (is_etx) begin
                    r_d.valid   = 1'b1;
                    r_d.cmd_out = r_q.cmd;
                    r_d.len_out = r_q.len;
                    r_d.st      = ST_HUNT;
                end else if (is_stx) begin
                    r_d.st = ST_SYNC;
                end else if (sym.vld) begin
                    r_d.st = ST_HUNT;
                end
            end
            default: r_d.st = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_HUNT;
        end else begin
            r_q <= r_d;
        end
    end

    assign pkt_valid = r_q.valid;
    assign pkt_cmd   = r_q.cmd_out;
    assign pkt_len   = r_q.len_out;

endmodule

// File: rtl/pkt_deframer.sv
module pkt_deframer
    import pkt_deframer_pkg::*;
#(
    parameter logic [7:0] STX_CODE  = 8'h0F,
    parameter logic [7:0] ETX_CODE  = 8'h05,
    parameter logic [7:0] DLE_CODE  = 8'h04,
    parameter int         BUF_DEPTH = 255
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic [7:0] rd_addr,
    output logic [7:0] rd_data,
    output logic       pkt_valid,
    output logic [7:0] pkt_cmd,
    output logic [7:0] pkt_len
);

    localparam int AW = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1;

    sym_t          sym;
    logic          we;
    logic [AW-1:0] wa;
    logic [7:0]    wd;
    logic [7:0]    ram_q;

    pkt_unescape #(.DLE_CODE(DLE_CODE)) u_unesc (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (rx_valid),
        .in_byte (rx_byte),
        .sym     (sym)
    );

    pkt_frame_fsm #(
        .STX_CODE (STX_CODE),
        .ETX_CODE (ETX_CODE),
        .DEPTH    (BUF_DEPTH),
        .AW       (AW)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sym       (sym),
        .wr_en     (we),
        .wr_addr   (wa),
        .wr_data   (wd),
        .pkt_valid (pkt_valid),
        .pkt_cmd   (pkt_cmd),
        .pkt_len   (pkt_len)
    );

    pkt_payload_ram #(.DEPTH(BUF_DEPTH), .AW(AW)) u_ram (
        .clk (clk),
        .we  (we),
        .wa  (wa),
        .wd  (wd),
        .ra  (rd_addr[AW-1:0]),
        .rd  (ram_q)
    );

    assign rd_data = (32'(rd_addr) < BUF_DEPTH) ? ram_q : 8'd0;

endmodule

// File: rtl/pkt_deframer_chk.sv
module pkt_deframer_chk #(
    parameter logic [7:0] ETX_CODE  = 8'h05,
    parameter int         BUF_DEPTH = 255
) (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_valid,
    input logic [7:0] rx_byte,
    input logic       pkt_valid,
    input logic [7:0] pkt_cmd,
    input logic [7:0] pkt_len
);

    // R9: single-cycle pulse
    p_pulse_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |=> !pkt_valid);

    // R3: a pulse follows an end byte taken at the previous edge
    p_end_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> ($past(rx_valid) && $past(rx_byte) == ETX_CODE));

    // R9: published fields move only with a pulse
    p_hold_fields_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_valid |-> ($stable(pkt_cmd) && $stable(pkt_len)));

    // R7: no accepted length beyond the buffer
    p_len_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> (32'(pkt_len) <= BUF_DEPTH));

    // R1: reset values
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!pkt_valid && pkt_cmd == 8'd0 && pkt_len == 8'd0));

endmodule

bind pkt_deframer pkt_deframer_chk #(
    .ETX_CODE  (ETX_CODE),
    .BUF_DEPTH (BUF_DEPTH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .rx_byte   (rx_byte),
    .pkt_valid (pkt_valid),
    .pkt_cmd   (pkt_cmd),
    .pkt_len   (pkt_len)
);

// File: tb/pkt_deframer_bench.sv
`timescale 1ns/1ps
module pkt_deframer_bench;

    localparam logic [7:0] STX = 8'h0F;
    localparam logic [7:0] ETX = 8'h05;
    localparam logic [7:0] DLE = 8'h04;
    localparam int         DEPTH = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'd0;
    logic [7:0] rd_addr = 8'd0;
    logic [7:0] rd_data;
    logic       pkt_valid;
    logic [7:0] pkt_cmd;
    logic [7:0] pkt_len;

    always #2.5 clk = ~clk;

    pkt_deframer #(.BUF_DEPTH(DEPTH)) u_pkt_deframer (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .pkt_valid (pkt_valid),
        .pkt_cmd   (pkt_cmd),
        .pkt_len   (pkt_len)
    );

    typedef struct {
        logic [7:0] cmd;
        logic [7:0] len;
        logic [7:0] d [0:255];
        int         due;
    } exp_t;

    exp_t       q [$];
    exp_t       e;
    logic [7:0] pay [0:255];
    int         n_chk = 0;
    int         n_bad = 0;
    int         cyc = 0;
    int         last_drive = 0;
    logic [7:0] last_cmd = 8'd0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input bit ok, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk);
        rx_valid   = 1'b1;
        rx_byte    = b;
        last_drive = cyc;
    endtask

    task automatic put_f(input logic [7:0] b);
        if (b == STX || b == ETX || b == DLE) put(DLE);
        put(b);
    endtask

    task automatic gap(input int n);
        repeat (n) begin
            @(negedge clk);
            rx_valid = 1'b0;
        end
    endtask

    // mode: 0 good, 1 bad checksum, 2 wrong end byte
    task automatic send(input logic [7:0] cmd, input int len, input int mode, input bit spaced);
        logic [7:0] s;
        logic [7:0] ck;
        exp_t x;
        s = cmd + 8'(len);
        for (int i = 0; i < len; i++) s = s + pay[i];
        ck = 8'd0 - s;
        if (mode == 1) ck = ck + 8'd1;
        put(STX);
        put(STX);
        put_f(cmd);
        if (spaced) gap(2);
        put_f(8'(len));
        for (int i = 0; i < len; i++) begin
            put_f(pay[i]);
            if (spaced) gap(1);
        end
        put_f(ck);
        put((mode == 2) ? 8'h33 : ETX);
        if (mode == 0) begin
            x.cmd = cmd;
            x.len = 8'(len);
            for (int i = 0; i < 256; i++) x.d[i] = pay[i];
            x.due = last_drive + 1;
            q.push_back(x);
            last_cmd = cmd;
        end
        gap(len + 4);
    endtask

    // monitor: pops expected packets as pulses appear
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && pkt_valid === 1'b1) begin
                if (q.size() == 0) begin
                    check("R5 unexpected packet cmd", 1'b0, pkt_cmd, 0);
                end else begin
                    e = q.pop_front();
                    check("R3 command", pkt_cmd == e.cmd, pkt_cmd, e.cmd);
                    check("R3 length", pkt_len == e.len, pkt_len, e.len);
                    check("R3 pulse cycle", cyc == e.due, cyc, e.due);
                    for (int i = 0; i < int'(e.len); i++) begin
                        rd_addr = 8'(i);
                        #0.05;
                        check("R3 payload byte", rd_data == e.d[i], rd_data, e.d[i]);
                    end
                    @(negedge clk);
                    check("R9 pulse width", pkt_valid == 1'b0, pkt_valid, 0);
                end
            end
        end
    end

    initial begin
        #1000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset valid", pkt_valid == 1'b0, pkt_valid, 0);
        check("R1 reset cmd", pkt_cmd == 8'd0, pkt_cmd, 0);
        check("R1 reset len", pkt_len == 8'd0, pkt_len, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", pkt_valid == 1'b0 && pkt_cmd == 8'd0, pkt_cmd, 0);

        // R3 plain packet
        for (int i = 0; i < 256; i++) pay[i] = 8'(i * 13 + 32);
        send(8'h21, 5, 0, 1'b0);

        // R4 control values in command, length and payload
        pay[0] = STX; pay[1] = ETX; pay[2] = DLE; pay[3] = 8'h77;
        send(STX, 4, 0, 1'b0);
        send(DLE, 6, 0, 1'b0);

        // R10 empty payload, command equal to the end code
        send(ETX, 0, 0, 1'b0);

        // R5 bad checksum, then hold check for R9
        send(8'h55, 3, 1, 1'b0);
        check("R9 command held after drop", pkt_cmd == last_cmd, pkt_cmd, last_cmd);

        // R6 missing end byte
        send(8'h56, 2, 2, 1'b0);
        check("R6 command held", pkt_cmd == last_cmd, pkt_cmd, last_cmd);

        // R7 oversize then exact fit
        send(8'h60, DEPTH + 1, 0, 1'b0);
        void'(q.pop_back());
        last_cmd = 8'h05;
        check("R7 oversize dropped", pkt_cmd == 8'h05, pkt_cmd, 8'h05);
        for (int i = 0; i < 256; i++) pay[i] = 8'(255 - i);
        send(8'h61, DEPTH, 0, 1'b0);

        // R8 restart inside a packet
        put(STX); put(STX); put(8'h40); put(8'h06); put(8'h11); put(8'h12);
        send(8'h41, 3, 0, 1'b0);

        // R2 a lone start byte does not open a packet
        put(STX); put(8'h11); put(8'h00); put(8'hEF); put(ETX);
        gap(4);
        check("R2 lone start ignored", pkt_cmd == 8'h41, pkt_cmd, 8'h41);
        // R2 extra start bytes before the command
        put(STX);
        send(8'h42, 2, 0, 1'b0);

        // R11 idle cycles between bytes
        send(8'h43, 7, 0, 1'b1);

        gap(10);
        check("R3 all expected packets seen", q.size() == 0, q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule